// File: doc/BRIEF.md
# External Interrupt Line Controller

This block turns sixteen pin-level inputs into interrupt requests and a shared wakeup event. Each line brings its input through a two-flop synchroniser and a deglitch filter of programmable length. A per-line detector then watches for the configured condition: high level, low level, falling edge, rising edge or either edge. A detected condition sets a sticky status bit for that line. The status bit drives that line's interrupt request when the line's interrupt enable is set. It also feeds a combined wakeup output when the line's wakeup enable is set. The two enables are separate.

Software reaches the block through a small word-wide register port. It can set up each line, read and clear the status bits, and raise an event on any line without pin activity. Choosing which pin feeds which line, prioritising the interrupts and acting on the wakeup are all left to neighbouring blocks.

Top module: `extint_ctrl`

## Requirements
- R1: After reset the interrupt enables, the wakeup enables and the status read 0. Every line configuration reads 0x3 (rising edge, filter 0). `irq_o` is 0 and `wake_o` is 0.
- R2: Trigger code 0 (high level) and code 1 (low level) set the line's status while the filtered input is at that level. If the level persists, the status bit stays set across a write-one-to-clear.
- R3: Edge trigger codes are 2 for falling, 3 for rising and 4 for either edge. Each sets the status once per matching transition of the filtered input. Codes 5 to 7 never set the status.
- R4: With filter length N in a line's configuration, a change of the synchronised input is rejected when it lasts N clocks or fewer. A change held for N+1 clocks is accepted. With N=0 a one-clock pulse is accepted.
- R5: Writing the status register clears each status bit whose data bit is 1 and leaves the bits written 0 unchanged. A detection in the same clock as the clear keeps the bit set.
- R6: `irq_o[i]` is high exactly when status bit i and interrupt enable bit i are both set.
- R7: `wake_o` is high when any line has both its status bit and its wakeup enable bit set. This does not depend on the interrupt enables.
- R8: Writing 1 to bit i of the software-trigger register sets status bit i whatever the pin level and trigger code. That register reads 0.
- R9: Register map by word address: 0 is the interrupt enable (bits 15:0). 1 is the wakeup enable (bits 15:0). 2 is the status (read, write one to clear). 3 is the software trigger. 4+i is the configuration of line i, with the trigger code in bits 2:0 and the filter length in bits 7:4. Enables and configurations read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 16 | Raw line inputs, asynchronous to clk |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i, combinational |
| irq_o | output | 16 | Per-line interrupt requests |
| wake_o | output | 1 | Combined wakeup event |

## Verification
The assertions take for granted that a line's trigger code and filter length hold steady while an input change is being filtered. They also assume the register port issues at most one write per clock. The bench changes a line's configuration only while that line's pin is quiet, and it leaves idle clocks before it drives the pin. It drives pins and register writes on the falling clock edge and holds each pulse for a whole number of clocks. That gives a defined pulse length on the synchronised input, so the filter limits N and N+1 can be hit exactly.

// File: rtl/extint_pkg.sv
`timescale 1ns/100ps
package extint_pkg;

    typedef enum logic [2:0] {
        TRG_HIGH = 3'd0,
        TRG_LOW  = 3'd1,
        TRG_FALL = 3'd2,
        TRG_RISE = 3'd3,
        TRG_BOTH = 3'd4
    } trig_e;

    localparam int unsigned KIND_W    = 3;
    localparam int unsigned ADR_IEN   = 0;
    localparam int unsigned ADR_WEN   = 1;
    localparam int unsigned ADR_STAT  = 2;
    localparam int unsigned ADR_SWTRG = 3;
    localparam int unsigned ADR_CFG0  = 4;
    localparam int unsigned FILT_LSB  = 4;

endpackage

// File: rtl/extint_sync.sv
`timescale 1ns/100ps
module extint_sync #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] in_i,
    output logic [W-1:0] out_o
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = in_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_o = st_q.s2;

endmodule

// File: rtl/extint_line.sv
`timescale 1ns/100ps
module extint_line
    import extint_pkg::*;
#(
    parameter int unsigned FILT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              raw_i,
    input  logic [KIND_W-1:0] kind_i,
    input  logic [FILT_W-1:0] flen_i,
    output logic              evt_o
);

    typedef struct packed {
        logic [FILT_W-1:0] cnt;
        logic              flt;
        logic              prev;
    } line_t;

    line_t st_d, st_q;

    // deglitch: a differing input must be seen on flen+1 clocks in a row
    always_comb begin
        st_d      = st_q;
        st_d.prev = st_q.flt;
        if (raw_i != st_q.flt) begin
            if (st_q.cnt >= flen_i) begin
                st_d.flt = raw_i;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_comb begin
        case (kind_i)
            TRG_HIGH: evt_o = st_q.flt;
            TRG_LOW:  evt_o = ~st_q.flt;
            TRG_FALL: evt_o = st_q.prev & ~st_q.flt;
            TRG_RISE: evt_o = ~st_q.prev & st_q.flt;
            TRG_BOTH: evt_o = st_q.prev ^ st_q.flt;
            default:  evt_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4: the filtered value only moves after the input differed long enough
    a_r4_filter_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.flt) |-> ($past(raw_i) != $past(st_q.flt)) &&
                               ($past(st_q.cnt) >= $past(flen_i)));

    // R3: a rising-edge event coincides with a rise of the filtered value
    a_r3_rise_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i == TRG_RISE && evt_o) |-> $rose(st_q.flt));

endmodule

// File: rtl/extint_ctrl.sv
`timescale 1ns/100ps
module extint_ctrl
    import extint_pkg::*;
#(
    parameter int unsigned NLINES = 16,
    parameter int unsigned FILT_W = 4,
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] pin_i,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic [NLINES-1:0] irq_o,
    output logic              wake_o
);

    localparam int unsigned CFG_W = KIND_W + FILT_W;
    localparam logic [CFG_W-1:0] CFG_RST = CFG_W'(TRG_RISE);

    typedef struct packed {
        logic [NLINES-1:0]             ien;
        logic [NLINES-1:0]             wen;
        logic [NLINES-1:0]             stat;
        logic [NLINES-1:0][CFG_W-1:0]  cfg;
    } regs_t;

    regs_t st_d, st_q;

    logic [NLINES-1:0] pin_s;
    logic [NLINES-1:0] hw_evt;
    logic [NLINES-1:0] clr_m;
    logic [NLINES-1:0] sw_m;

    extint_sync #(.W(NLINES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .in_i  (pin_i),
        .out_o (pin_s)
    );

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        extint_line #(.FILT_W(FILT_W)) u_line (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (pin_s[g]),
            .kind_i (st_q.cfg[g][KIND_W-1:0]),
            .flen_i (st_q.cfg[g][CFG_W-1:KIND_W]),
            .evt_o  (hw_evt[g])
        );
    end

    always_comb begin
        st_d  = st_q;
        clr_m = '0;
        sw_m  = '0;
        if (reg_wr_i) begin
            if (reg_addr_i == ADDR_W'(ADR_IEN))   st_d.ien = reg_wdata_i[NLINES-1:0];
            if (reg_addr_i == ADDR_W'(ADR_WEN))   st_d.wen = reg_wdata_i[NLINES-1:0];
            if (reg_addr_i == ADDR_W'(ADR_STAT))  clr_m    = reg_wdata_i[NLINES-1:0];
            if (reg_addr_i == ADDR_W'(ADR_SWTRG)) sw_m     = reg_wdata_i[NLINES-1:0];
            for (int i = 0; i < NLINES; i++) begin
                if (reg_addr_i == ADDR_W'(ADR_CFG0 + i)) begin
                    st_d.cfg[i] = {reg_wdata_i[FILT_LSB +: FILT_W],
                                   reg_wdata_i[KIND_W-1:0]};
                end
            end
        end
        // an event in the same clock as a clear keeps the bit
        st_d.stat = (st_q.stat & ~clr_m) | hw_evt | sw_m;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ien  <= '0;
            st_q.wen  <= '0;
            st_q.stat <= '0;
            st_q.cfg  <= {NLINES{CFG_RST}};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata_o = '0;
        if (reg_addr_i == ADDR_W'(ADR_IEN))  reg_rdata_o = DATA_W'(st_q.ien);
        if (reg_addr_i == ADDR_W'(ADR_WEN))  reg_rdata_o = DATA_W'(st_q.wen);
        if (reg_addr_i == ADDR_W'(ADR_STAT)) reg_rdata_o = DATA_W'(st_q.stat);
        for (int i = 0; i < NLINES; i++) begin
            if (reg_addr_i == ADDR_W'(ADR_CFG0 + i)) begin
                reg_rdata_o[KIND_W-1:0]          = st_q.cfg[i][KIND_W-1:0];
                reg_rdata_o[FILT_LSB +: FILT_W]  = st_q.cfg[i][CFG_W-1:KIND_W];
            end
        end
    end

    assign irq_o  = st_q.stat & st_q.ien;
    assign wake_o = |(st_q.stat & st_q.wen);

    // R5: a status bit only falls when it was written with a 1
    a_r5_clear_by_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        ((~st_q.stat & $past(st_q.stat)) & ~$past(clr_m)) == '0);

    // R8: a software trigger always leaves its bits set
    a_r8_sw_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (|sw_m) |=> ((st_q.stat & $past(sw_m)) == $past(sw_m)));

    // R5: a detection never loses against a clear in the same clock
    a_r5_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|hw_evt) |=> ((st_q.stat & $past(hw_evt)) == $past(hw_evt)));

endmodule

// File: tb/sim_extint_ctrl.sv
`timescale 1ns/100ps
module sim_extint_ctrl;

    localparam int NL = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [NL-1:0] pin = '0;
    logic        wr = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [NL-1:0] irq;
    logic        wake;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];
    event  smp_ev;

    always #2.5 clk = ~clk;

    extint_ctrl u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_i       (pin),
        .reg_wr_i    (wr),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .irq_o       (irq),
        .wake_o      (wake)
    );

    // monitor: pops expected items and compares with the live outputs
    initial begin
        forever begin
            @(smp_ev);
            while (sb_q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sb_q.pop_front();
                case (it.kind)
                    0:       act = rdata;
                    1:       act = 32'(irq);
                    default: act = {31'd0, wake};
                endcase
                n_chk++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic push_exp(input int kind, input logic [31:0] exp, input string tag);
        item_t it;
        it.kind = kind; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        -> smp_ev;
        #0.5;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_reg(input int a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = 6'(a); wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic chk_reg(input int a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        addr = 6'(a);
        #0.5;
        push_exp(0, exp, tag);
    endtask

    task automatic clear_all();
        wr_reg(2, 32'h0000_FFFF);
    endtask

    task automatic pulse(input int line, input int len);
        @(negedge clk);
        pin[line] = 1'b1;
        tick(len);
        pin[line] = 1'b0;
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(2);

        // R1 reset state
        chk_reg(0, 32'h0, "R1 ien reset");
        chk_reg(1, 32'h0, "R1 wen reset");
        chk_reg(2, 32'h0, "R1 status reset");
        chk_reg(4, 32'h3, "R1 cfg line0 reset");
        chk_reg(19, 32'h3, "R1 cfg line15 reset");
        push_exp(1, 32'h0, "R1 irq reset");
        push_exp(2, 32'h0, "R1 wake reset");

        // R9 register readback
        wr_reg(0, 32'h0000_A5A5);
        chk_reg(0, 32'h0000_A5A5, "R9 ien readback");
        wr_reg(1, 32'h0000_3C3C);
        chk_reg(1, 32'h0000_3C3C, "R9 wen readback");
        wr_reg(5, 32'h0000_0052);
        chk_reg(5, 32'h0000_0052, "R9 cfg line1 readback");
        chk_reg(3, 32'h0, "R8 swtrig reads zero");
        wr_reg(5, 32'h3);
        wr_reg(0, 32'h0);
        wr_reg(1, 32'h0);
        tick(4);
        clear_all();

        // R3 rising edge on line 2
        wr_reg(6, 32'h3);
        tick(2);
        pin[2] = 1'b1; tick(8);
        chk_reg(2, 32'h0000_0004, "R3 rise sets");
        clear_all();
        pin[2] = 1'b0; tick(8);
        chk_reg(2, 32'h0, "R3 rise ignores fall");

        // R3 falling edge on line 3
        wr_reg(7, 32'h2);
        tick(2);
        pin[3] = 1'b1; tick(8);
        chk_reg(2, 32'h0, "R3 fall ignores rise");
        pin[3] = 1'b0; tick(8);
        chk_reg(2, 32'h0000_0008, "R3 fall sets");
        clear_all();

        // R3 both edges on line 4
        wr_reg(8, 32'h4);
        tick(2);
        pin[4] = 1'b1; tick(8);
        chk_reg(2, 32'h0000_0010, "R3 both rise");
        clear_all();
        pin[4] = 1'b0; tick(8);
        chk_reg(2, 32'h0000_0010, "R3 both fall");
        clear_all();

        // R3 reserved code on line 5
        wr_reg(9, 32'h5);
        tick(2);
        pin[5] = 1'b1; tick(8);
        pin[5] = 1'b0; tick(8);
        chk_reg(2, 32'h0, "R3 code5 no event");

        // R2 high level on line 6, with clear while high (R5)
        wr_reg(10, 32'h0);
        tick(2);
        chk_reg(2, 32'h0, "R2 high idle low");
        pin[6] = 1'b1; tick(8);
        chk_reg(2, 32'h0000_0040, "R2 high sets");
        clear_all();
        chk_reg(2, 32'h0000_0040, "R5 level wins over clear");
        pin[6] = 1'b0; tick(8);
        clear_all();
        chk_reg(2, 32'h0, "R2 high released clears");

        // R2 low level on line 7
        wr_reg(11, 32'h1);
        tick(3);
        clear_all();
        chk_reg(2, 32'h0000_0080, "R2 low persists");
        pin[7] = 1'b1; tick(8);
        clear_all();
        chk_reg(2, 32'h0, "R2 low released");

        // R5 partial clear leaves other bits
        wr_reg(3, 32'h0000_0300);
        wr_reg(2, 32'h0000_0100);
        chk_reg(2, 32'h0000_0200, "R5 partial clear");
        clear_all();

        // R4 deglitch, filter 3 on line 8 (rising)
        wr_reg(12, 32'h33);
        tick(2);
        pulse(8, 3); tick(10);
        chk_reg(2, 32'h0, "R4 pulse N blocked");
        pulse(8, 4); tick(10);
        chk_reg(2, 32'h0000_0100, "R4 pulse N+1 passes");
        clear_all();

        // R4 filter 0 on line 9: one-clock pulse passes
        wr_reg(13, 32'h03);
        tick(2);
        pulse(9, 1); tick(8);
        chk_reg(2, 32'h0000_0200, "R4 filter0 one clock");
        clear_all();

        // R8 software trigger on line 15, pin quiet
        wr_reg(3, 32'h0000_8000);
        chk_reg(2, 32'h0000_8000, "R8 sw trigger sets");

        // R6 / R7 enables
        wr_reg(0, 32'h0000_8000);
        tick(1);
        push_exp(1, 32'h0000_8000, "R6 irq follows enable");
        push_exp(2, 32'h0, "R7 wake off without enable");
        wr_reg(0, 32'h0);
        wr_reg(1, 32'h0000_8000);
        tick(1);
        push_exp(1, 32'h0, "R6 irq masked");
        push_exp(2, 32'h1, "R7 wake without irq enable");
        wr_reg(1, 32'h0000_0001);
        tick(1);
        push_exp(2, 32'h0, "R7 wake other line");
        clear_all();
        wr_reg(0, 32'h0000_FFFF);
        tick(1);
        push_exp(1, 32'h0, "R6 irq after clear");

        tick(4);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule